// File: doc/BRIEF.md
# Dual-Pipe Floating-Point Issue Scheduler

This block is the issue stage in front of a floating-point execution unit. A two-slot holding station accepts operations through a valid/ready handshake. Each operation carries an opcode and an extended-precision operand, sent as a high half and a low half of 41 bits each. In every cycle the station sends at most one arithmetic operation to either the add pipeline or the multiply pipeline. In the same cycle it can also retire a register-exchange operation, which never enters a pipeline.

The two pipelines have different lengths (3 and 4 cycles by default). They merge into one rounding stage that can deliver only one result per clock. A small reservation shift register records the future cycles in which the rounder is already claimed. An operation whose result would land in a claimed cycle stays in its slot. The other slot may issue past it if its own pipeline lands in a free cycle. Both pipelines are modelled as fixed-latency delay lines that carry the slot tag and the operand unchanged to the rounder output. The arithmetic itself is outside this block.

The reset input is asserted asynchronously and is released inside the block after two clock edges.

Top module: `fp_issue_sched`

## Requirements
- R1: The station has two slots. `in_ready` is low exactly when both slots are occupied. An operation offered with `in_valid` and `in_ready` both high is written into the lowest-numbered free slot, and that slot number (0 or 1) is its tag. A slot freed in a cycle can be refilled no earlier than the next cycle.
- R2: Opcode 00 is add and 01 is multiply; any opcode with bit 1 set is a register exchange. At most one of `add_iss_valid` and `mul_iss_valid` is high in a cycle. An accepted operation can issue at the earliest in the cycle after it is accepted. Its slot is free from the next cycle.
- R3: An exchange completes in the issue stage. `xch_done` pulses with its tag in the first cycle it is held. It uses neither pipeline nor the rounder, and it does not prevent an arithmetic issue from the other slot in the same cycle.
- R4: When both slots hold operations that can issue, the one accepted earlier issues first. The same rule applies to two exchanges.
- R5: An add issued in cycle c appears on the rounder output in cycle c+3, and a multiply in cycle c+4. The output carries the slot tag, a source bit (0 add, 1 multiply) and both operand halves unchanged.
- R6: An arithmetic operation is held while its result would reach the rounder in a cycle already claimed by a result in flight. A held operation does not block the other slot from issuing if that slot's result lands in a free cycle. Two results never reach the rounder in the same cycle.
- R7: During and right after reset both slots are empty, `in_ready` is high, and every valid output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | A slot is free |
| in_op | input | 2 | Opcode: 00 add, 01 multiply, 1x exchange |
| in_hi | input | 41 | Operand high half |
| in_lo | input | 41 | Operand low half |
| add_iss_valid | output | 1 | Issue to add pipeline this cycle |
| add_iss_tag | output | 1 | Slot tag of the add issue |
| add_iss_hi | output | 41 | Operand high half to add pipeline |
| add_iss_lo | output | 41 | Operand low half to add pipeline |
| mul_iss_valid | output | 1 | Issue to multiply pipeline this cycle |
| mul_iss_tag | output | 1 | Slot tag of the multiply issue |
| mul_iss_hi | output | 41 | Operand high half to multiply pipeline |
| mul_iss_lo | output | 41 | Operand low half to multiply pipeline |
| xch_done | output | 1 | Exchange completed this cycle |
| xch_tag | output | 1 | Slot tag of the completed exchange |
| rnd_valid | output | 1 | Rounder delivers a result |
| rnd_tag | output | 1 | Tag of the delivered result |
| rnd_src | output | 1 | 0 from add pipeline, 1 from multiply pipeline |
| rnd_hi | output | 41 | Result high half |
| rnd_lo | output | 41 | Result low half |

## Verification
The issue ports and `xch_done` depend only on registered slot state, so they are due in the cycle after acceptance. Rounder results are due exactly 3 or 4 cycles after their issue cycle. The bench keeps a behavioural reference: slots ordered by an arrival counter, plus an array of future rounder cycles that shifts by one every clock. Inputs change on the falling edge, and a quarter period later every output is compared with the reference's values for that same cycle. A result delayed by a collision, a held older operation or an off-by-one latency therefore shows up in the cycle where it occurs.

// File: rtl/fp_sched_pkg.sv
package fp_sched_pkg;
  localparam int unsigned SLOTS = 2;
  localparam logic [1:0] OPC_ADD = 2'b00;
  localparam logic [1:0] OPC_MUL = 2'b01;

  function automatic logic op_is_xch(input logic [1:0] op);
    return op[1];
  endfunction

  function automatic logic op_is_mul(input logic [1:0] op);
    return (op == OPC_MUL);
  endfunction
endpackage

// File: rtl/fp_rs_station.sv
module fp_rs_station
  import fp_sched_pkg::*;
#(
  parameter int PW = 82
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_op,
  input  logic [PW-1:0] in_data,
  output logic          in_ready,
  input  logic          add_blk,
  input  logic          mul_blk,
  output logic          iss_valid,
  output logic          iss_tag,
  output logic          iss_mul,
  output logic [PW-1:0] iss_data,
  output logic          xch_valid,
  output logic          xch_tag
);
  logic [SLOTS-1:0] vld_q, vld_d;
  logic             old_q, old_d;
  logic [1:0]       op_q   [SLOTS];
  logic [PW-1:0]    data_q [SLOTS];

  logic [SLOTS-1:0] arith_ok, xch_ok, freed, kept, load_en;
  logic             pri0, pri1, accept, alloc_idx;

  always_comb begin
    pri0 = (vld_q[0] && vld_q[1]) ? old_q : vld_q[1];
    pri1 = ~pri0;
    for (int i = 0; i < SLOTS; i++) begin
      arith_ok[i] = vld_q[i] && !op_is_xch(op_q[i]) &&
                    !(op_is_mul(op_q[i]) ? mul_blk : add_blk);
      xch_ok[i]   = vld_q[i] && op_is_xch(op_q[i]);
    end
    iss_valid = arith_ok[pri0] || arith_ok[pri1];
    iss_tag   = arith_ok[pri0] ? pri0 : pri1;
    iss_mul   = op_is_mul(op_q[iss_tag]);
    iss_data  = data_q[iss_tag];
    xch_valid = xch_ok[pri0] || xch_ok[pri1];
    xch_tag   = xch_ok[pri0] ? pri0 : pri1;

    in_ready  = ~(vld_q[0] && vld_q[1]);
    accept    = in_valid && in_ready;
    alloc_idx = vld_q[0];
    for (int i = 0; i < SLOTS; i++) begin
      freed[i]   = (iss_valid && (iss_tag == i[0])) || (xch_valid && (xch_tag == i[0]));
      kept[i]    = vld_q[i] && !freed[i];
      load_en[i] = accept && (alloc_idx == i[0]);
      vld_d[i]   = kept[i] || load_en[i];
    end

    if (kept[0] && kept[1])      old_d = old_q;
    else if (kept[0])            old_d = 1'b0;
    else if (kept[1])            old_d = 1'b1;
    else                         old_d = alloc_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      old_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      old_q <= old_d;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (load_en[g]) begin
        op_q[g]   <= in_op;
        data_q[g] <= in_data;
      end
    end
  end
endmodule

// File: rtl/fp_rnd_resv.sv
module fp_rnd_resv #(
  parameter int ADD_LAT = 3,
  parameter int MUL_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic add_go,
  input  logic mul_go,
  output logic add_blk,
  output logic mul_blk
);
  localparam int MAXL = (ADD_LAT > MUL_LAT) ? ADD_LAT : MUL_LAT;
  localparam int AIDX = (ADD_LAT > 1) ? ADD_LAT - 1 : 1;
  localparam int MIDX = (MUL_LAT > 1) ? MUL_LAT - 1 : 1;

  logic [MAXL:1] slot_q, slot_d;

  always_comb begin
    slot_d = {1'b0, slot_q[MAXL:2]};
    if (ADD_LAT > 1) slot_d[AIDX] = slot_d[AIDX] | add_go;
    if (MUL_LAT > 1) slot_d[MIDX] = slot_d[MIDX] | mul_go;
    add_blk = slot_q[ADD_LAT];
    mul_blk = slot_q[MUL_LAT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end
endmodule

// File: rtl/fp_delay_line.sv
module fp_delay_line #(
  parameter int W     = 83,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  if (DEPTH == 0) begin : g_wire
    assign out_v = in_v;
    assign out_d = in_d;
  end else begin : g_regs
    logic         v_q [DEPTH+1];
    logic [W-1:0] d_q [DEPTH+1];
    assign v_q[0] = in_v;
    assign d_q[0] = in_d;
    for (genvar s = 1; s <= DEPTH; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q[s] <= 1'b0;
        else        v_q[s] <= v_q[s-1];
      end
      always_ff @(posedge clk) begin
        if (v_q[s-1]) d_q[s] <= d_q[s-1];
      end
    end
    assign out_v = v_q[DEPTH];
    assign out_d = d_q[DEPTH];
  end
endmodule

// File: rtl/fp_rnd_port.sv
module fp_rnd_port #(
  parameter int W = 83
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_v,
  input  logic [W-1:0] a_d,
  input  logic         m_v,
  input  logic [W-1:0] m_d,
  output logic         r_v,
  output logic         r_src,
  output logic [W-1:0] r_d
);
  logic         sel_v, sel_src;
  logic [W-1:0] sel_d;

  always_comb begin
    sel_v   = a_v || m_v;
    sel_src = m_v;
    sel_d   = m_v ? m_d : a_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_v <= 1'b0;
    else        r_v <= sel_v;
  end

  always_ff @(posedge clk) begin
    if (sel_v) begin
      r_src <= sel_src;
      r_d   <= sel_d;
    end
  end
endmodule

// File: rtl/fp_issue_sched.sv
module fp_issue_sched #(
  parameter int HALF_W  = 41,
  parameter int ADD_LAT = 3,
  parameter int MUL_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [HALF_W-1:0] in_hi,
  input  logic [HALF_W-1:0] in_lo,
  output logic              add_iss_valid,
  output logic              add_iss_tag,
  output logic [HALF_W-1:0] add_iss_hi,
  output logic [HALF_W-1:0] add_iss_lo,
  output logic              mul_iss_valid,
  output logic              mul_iss_tag,
  output logic [HALF_W-1:0] mul_iss_hi,
  output logic [HALF_W-1:0] mul_iss_lo,
  output logic              xch_done,
  output logic              xch_tag,
  output logic              rnd_valid,
  output logic              rnd_tag,
  output logic              rnd_src,
  output logic [HALF_W-1:0] rnd_hi,
  output logic [HALF_W-1:0] rnd_lo
);
  localparam int EXT_W = 2 * HALF_W;
  localparam int PAY_W = EXT_W + 1;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             iss_valid, iss_tag, iss_mul, add_blk, mul_blk;
  logic [EXT_W-1:0] iss_data;
  logic             add_go, mul_go;

  fp_rs_station #(.PW(EXT_W)) u_station (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_data   ({in_hi, in_lo}),
    .in_ready  (in_ready),
    .add_blk   (add_blk),
    .mul_blk   (mul_blk),
    .iss_valid (iss_valid),
    .iss_tag   (iss_tag),
    .iss_mul   (iss_mul),
    .iss_data  (iss_data),
    .xch_valid (xch_done),
    .xch_tag   (xch_tag)
  );

  assign add_go = iss_valid && !iss_mul;
  assign mul_go = iss_valid &&  iss_mul;

  fp_rnd_resv #(.ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)) u_resv (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .add_go  (add_go),
    .mul_go  (mul_go),
    .add_blk (add_blk),
    .mul_blk (mul_blk)
  );

  always_comb begin
    add_iss_valid = add_go;
    mul_iss_valid = mul_go;
    add_iss_tag   = add_go && iss_tag;
    mul_iss_tag   = mul_go && iss_tag;
    add_iss_hi    = add_go ? iss_data[EXT_W-1:HALF_W] : '0;
    add_iss_lo    = add_go ? iss_data[HALF_W-1:0]     : '0;
    mul_iss_hi    = mul_go ? iss_data[EXT_W-1:HALF_W] : '0;
    mul_iss_lo    = mul_go ? iss_data[HALF_W-1:0]     : '0;
  end

  logic             add_tail_v, mul_tail_v;
  logic [PAY_W-1:0] add_tail_d, mul_tail_d, rnd_pay;
  logic             rnd_src_q;

  fp_delay_line #(.W(PAY_W), .DEPTH(ADD_LAT - 1)) u_add_pipe (
    .clk   (clk),
    .rst_n (rst_int_n),
    .in_v  (add_go),
    .in_d  ({iss_tag, iss_data}),
    .out_v (add_tail_v),
    .out_d (add_tail_d)
  );

  fp_delay_line #(.W(PAY_W), .DEPTH(MUL_LAT - 1)) u_mul_pipe (
    .clk   (clk),
    .rst_n (rst_int_n),
    .in_v  (mul_go),
    .in_d  ({iss_tag, iss_data}),
    .out_v (mul_tail_v),
    .out_d (mul_tail_d)
  );

  fp_rnd_port #(.W(PAY_W)) u_rnd (
    .clk   (clk),
    .rst_n (rst_int_n),
    .a_v   (add_tail_v),
    .a_d   (add_tail_d),
    .m_v   (mul_tail_v),
    .m_d   (mul_tail_d),
    .r_v   (rnd_valid),
    .r_src (rnd_src_q),
    .r_d   (rnd_pay)
  );

  always_comb begin
    rnd_tag = rnd_valid && rnd_pay[PAY_W-1];
    rnd_src = rnd_valid && rnd_src_q;
    rnd_hi  = rnd_valid ? rnd_pay[EXT_W-1:HALF_W] : '0;
    rnd_lo  = rnd_valid ? rnd_pay[HALF_W-1:0]     : '0;
  end
endmodule

// File: rtl/fp_issue_sched_chk.sv
module fp_issue_sched_chk #(
  parameter int ADD_LAT = 3,
  parameter int MUL_LAT = 4
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic add_iss_valid,
  input logic add_iss_tag,
  input logic mul_iss_valid,
  input logic mul_iss_tag,
  input logic xch_done,
  input logic xch_tag,
  input logic rnd_valid,
  input logic add_tail_v,
  input logic mul_tail_v
);
  p_one_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(add_iss_valid && mul_iss_valid));

  p_xch_off_pipe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xch_done |-> (!add_iss_valid || add_iss_tag != xch_tag) &&
                 (!mul_iss_valid || mul_iss_tag != xch_tag));

  p_add_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    add_iss_valid |-> ##ADD_LAT rnd_valid);

  p_mul_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mul_iss_valid |-> ##MUL_LAT rnd_valid);

  p_no_collide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(add_tail_v && mul_tail_v));

  p_full_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !add_iss_valid && !mul_iss_valid && !xch_done) |=> !in_ready);

  p_idle_after_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> in_ready && !add_iss_valid && !mul_iss_valid && !xch_done);

  p_hold_when_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(in_ready) || add_iss_valid || mul_iss_valid || xch_done
                               || $past(add_iss_valid || mul_iss_valid || xch_done));
endmodule

bind fp_issue_sched fp_issue_sched_chk #(.ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .add_iss_valid (add_iss_valid),
  .add_iss_tag   (add_iss_tag),
  .mul_iss_valid (mul_iss_valid),
  .mul_iss_tag   (mul_iss_tag),
  .xch_done      (xch_done),
  .xch_tag       (xch_tag),
  .rnd_valid     (rnd_valid),
  .add_tail_v    (add_tail_v),
  .mul_tail_v    (mul_tail_v)
);

// File: tb/tb_fp_issue_sched.sv
module tb_fp_issue_sched;
  localparam int NCYC = 4000;

  logic        clk, rst_n, in_valid, in_ready;
  logic [1:0]  in_op;
  logic [40:0] in_hi, in_lo;
  logic        add_iss_valid, add_iss_tag, mul_iss_valid, mul_iss_tag;
  logic [40:0] add_iss_hi, add_iss_lo, mul_iss_hi, mul_iss_lo;
  logic        xch_done, xch_tag, rnd_valid, rnd_tag, rnd_src;
  logic [40:0] rnd_hi, rnd_lo;

  fp_issue_sched dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_hi(in_hi), .in_lo(in_lo),
    .add_iss_valid(add_iss_valid), .add_iss_tag(add_iss_tag),
    .add_iss_hi(add_iss_hi), .add_iss_lo(add_iss_lo),
    .mul_iss_valid(mul_iss_valid), .mul_iss_tag(mul_iss_tag),
    .mul_iss_hi(mul_iss_hi), .mul_iss_lo(mul_iss_lo),
    .xch_done(xch_done), .xch_tag(xch_tag),
    .rnd_valid(rnd_valid), .rnd_tag(rnd_tag), .rnd_src(rnd_src),
    .rnd_hi(rnd_hi), .rnd_lo(rnd_lo)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit          mv [2];
  int          mop[2];
  logic [40:0] mhi[2], mlo[2];
  int          mseq[2];
  int          seqc = 0;
  bit          fv [8];
  int          ftag[8], fsrc[8];
  logic [40:0] fhi[8], flo[8];

  task automatic ref_cycle(input bit check_on);
    bit e_ready, a_pick, x_pick, alloc;
    int o[2], ai, xi, lat, aslot;
    e_ready = !(mv[0] && mv[1]);
    if (mv[0] && mv[1]) o[0] = (mseq[0] < mseq[1]) ? 0 : 1;
    else                o[0] = mv[1] ? 1 : 0;
    o[1] = 1 - o[0];
    a_pick = 0; x_pick = 0; ai = 0; xi = 0;
    for (int k = 0; k < 2; k++) begin
      int s = o[k];
      if (!a_pick && mv[s] && mop[s] < 2 && !fv[(mop[s] == 1) ? 4 : 3]) begin
        a_pick = 1; ai = s;
      end
      if (!x_pick && mv[s] && mop[s] >= 2) begin
        x_pick = 1; xi = s;
      end
    end
    if (check_on) begin
      chk("R1", "in_ready", in_ready, e_ready);
      chk("R2/R4/R6", "add_iss_valid", add_iss_valid, a_pick && mop[ai] == 0);
      chk("R2/R4/R6", "mul_iss_valid", mul_iss_valid, a_pick && mop[ai] == 1);
      if (a_pick && mop[ai] == 0) begin
        chk("R4", "add_iss_tag", add_iss_tag, ai);
        chk("R5", "add_iss_hi", add_iss_hi, mhi[ai]);
        chk("R5", "add_iss_lo", add_iss_lo, mlo[ai]);
      end
      if (a_pick && mop[ai] == 1) begin
        chk("R4", "mul_iss_tag", mul_iss_tag, ai);
        chk("R5", "mul_iss_hi", mul_iss_hi, mhi[ai]);
        chk("R5", "mul_iss_lo", mul_iss_lo, mlo[ai]);
      end
      chk("R3", "xch_done", xch_done, x_pick);
      if (x_pick) chk("R3", "xch_tag", xch_tag, xi);
      chk("R5/R6", "rnd_valid", rnd_valid, fv[0]);
      if (fv[0]) begin
        chk("R5", "rnd_tag", rnd_tag, ftag[0]);
        chk("R5", "rnd_src", rnd_src, fsrc[0]);
        chk("R5", "rnd_hi", rnd_hi, fhi[0]);
        chk("R5", "rnd_lo", rnd_lo, flo[0]);
      end
    end
    alloc = in_valid && e_ready;
    aslot = mv[0] ? 1 : 0;
    if (a_pick) begin
      lat = (mop[ai] == 1) ? 4 : 3;
      fv[lat] = 1; ftag[lat] = ai; fsrc[lat] = mop[ai];
      fhi[lat] = mhi[ai]; flo[lat] = mlo[ai];
      mv[ai] = 0;
    end
    if (x_pick) mv[xi] = 0;
    for (int k = 0; k < 7; k++) begin
      fv[k] = fv[k+1]; ftag[k] = ftag[k+1]; fsrc[k] = fsrc[k+1];
      fhi[k] = fhi[k+1]; flo[k] = flo[k+1];
    end
    fv[7] = 0;
    if (alloc) begin
      mv[aslot] = 1; mop[aslot] = in_op; mhi[aslot] = in_hi; mlo[aslot] = in_lo;
      mseq[aslot] = seqc; seqc++;
    end
  endtask

  function automatic logic [1:0] pick_op(input int phase);
    int r = $urandom_range(0, 99);
    case (phase)
      0: return (r < 60) ? 2'b00 : 2'b10;
      1: return (r < 50) ? 2'b01 : ((r < 90) ? 2'b00 : 2'b11);
      default: return (r < 35) ? 2'b00 : ((r < 70) ? 2'b01 : ((r < 85) ? 2'b10 : 2'b11));
    endcase
  endfunction

  initial begin
    int phase, vprob;
    void'($urandom(7));
    for (int k = 0; k < 8; k++) fv[k] = 0;
    mv[0] = 0; mv[1] = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_op = 2'b00; in_hi = '0; in_lo = '0;
    repeat (3) @(negedge clk);
    #5;
    // R7: idle state while reset is held
    chk("R7", "in_ready in reset", in_ready, 1);
    chk("R7", "issue valids in reset", {add_iss_valid, mul_iss_valid, xch_done, rnd_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      phase = (c < 800) ? 0 : (c < 1800) ? 1 : (c < 2800) ? 2 : 3;
      vprob = (phase == 3) ? 100 : (phase == 2) ? 45 : 80;
      // directed: add, exchange, add, mul, add back-to-back (R3, R6)
      if (c >= 4 && c < 9) begin
        in_valid = 1'b1;
        in_op = (c == 5) ? 2'b10 : (c == 7) ? 2'b01 : 2'b00;
      end else if (c < 4 || (c >= 9 && c < 20)) begin
        in_valid = 1'b0;
      end else begin
        in_valid = ($urandom_range(0, 99) < vprob);
        in_op = pick_op(phase);
      end
      in_hi = {$urandom, $urandom};
      in_lo = {$urandom, $urandom};
      #5;
      if (c == 3) begin
        chk("R7", "in_ready after reset", in_ready, 1);
        chk("R7", "valids after reset", {add_iss_valid, mul_iss_valid, xch_done, rnd_valid}, 0);
      end
      ref_cycle(1'b1);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule